// File: doc/BRIEF.md
# Bus Beat and Cycle Performance Counter

This block watches a bus from the side and counts activity so that software can measure bus load over a time window. A bus monitor gives it two single-cycle strobes: one marks a read data beat and one marks a write data beat. The block holds one cycle counter and four event counters. Each event counter has its own select register that picks read beats, write beats or both. The last event counter is wider than the others. Software reads it in two parts: a low word and a high word.

Software uses a small synchronous register port. A typical window goes like this. Software picks the events and sets the wanted bits in the enable mask. One control write then clears the counters and starts counting. Later a second control write stops counting, and the counters hold their values. Software can then read the cycle total and the event totals as one consistent snapshot. The enable mask is changed through two registers: writing ones to one register sets mask bits, and writing ones to the other clears them. This way no read-modify-write is needed. Counting begins only when software sets the run bit; the block has no automatic start.

Top module: `bus_perf_counter`

## Requirements
- R1: After reset the run bit, the enable mask, every event select and every counter are zero, so every register reads as 0.
- R2: Writing to byte offset 0x04 ORs the write data into the enable mask, and writing to 0x08 clears each mask bit written as 1. Bits written as 0 leave the mask unchanged. Mask bit i (i = 0..3) enables event counter i and bit 4 enables the cycle counter. Both offsets read back the mask in bits [4:0].
- R3: The control register at 0x00 has three bits. Bit 0 is the run bit and reads back as last written. Bit 1 clears all event counters. Bit 2 clears the cycle counter. A clear takes effect at the clock edge of the write, overrides any count in that cycle, and reads back as 0. Counting restarts at the following edge when run is 1.
- R4: The cycle counter at 0x0C adds exactly 1 on every clock in which the run bit and mask bit 4 are both 1.
- R5: While the run bit is 0, no counter changes, except through a clear written to the control register.
- R6: The select register of event counter i sits at 0x30 + 4*i and reads back in bits [1:0]. Bit 0 counts read beats and bit 1 counts write beats. With both bits set and both beats in one cycle, the counter adds 2. Code 0 counts nothing. Counter i advances only while the run bit and mask bit i are both 1. Counters 0..2 read at 0x10, 0x14 and 0x18.
- R7: Event counter 3 is WIDE_W bits wide. Offset 0x1C returns its low CNT_W bits. Offset 0x20 returns its upper WIDE_W-CNT_W bits in the low bits of the word, with zeros above them. A carry out of the low part shows up in the high part.
- R8: Every counter wraps to zero modulo its own width.
- R9: Reads of unmapped offsets, or of addresses with nonzero bits [1:0], return 0. Writes to such addresses change nothing, and neither do writes to the read-only counter offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rd_beat | input | 1 | One read data beat seen on the bus this cycle |
| wr_beat | input | 1 | One write data beat seen on the bus this cycle |

## Verification
The checker module watches several behaviours on every cycle. These are the set and clear updates of the enable mask, the run bit readback, the cycle-counter clear strobe, the exact +1 step of the cycle counter, the hold of the counters while stopped, and the bound of at most 2 per cycle on the wide counter. Other behaviours appear only over longer runs, so only the bench scenarios can show them. These are the event selection per counter, wrap-around after a full count, the carry from the low to the high half of the wide counter, and that writes to unmapped or read-only offsets are ignored. The bench drives these scenarios against a behavioural model and compares the value read from the addressed register on every clock.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

  localparam int DATA_W = 32;

  // Word indexes (byte offset / 4) of the register map.
  localparam int W_CTRL     = 0;
  localparam int W_MASK_SET = 1;
  localparam int W_MASK_CLR = 2;
  localparam int W_CYCLES   = 3;
  localparam int W_EVT_BASE = 4;
  localparam int W_SEL_BASE = 12;

  // Control bit positions.
  localparam int CTRL_RUN     = 0;
  localparam int CTRL_EVT_CLR = 1;
  localparam int CTRL_CYC_CLR = 2;

  // Event select bit positions.
  localparam int SEL_RD = 0;
  localparam int SEL_WR = 1;

  typedef logic [1:0] evt_sel_t;
  typedef logic [1:0] step_t;

endpackage

// File: rtl/perf_ctrl_regs.sv
module perf_ctrl_regs
  import perf_mon_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int WORD_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [WORD_W-1:0]      wr_word,
  input  logic [DATA_W-1:0]      wdata,
  output logic                   run,
  output logic                   evt_clr,
  output logic                   cyc_clr,
  output logic [NUM_EVT:0]       mask,
  output evt_sel_t [NUM_EVT-1:0] sel
);

  localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(W_CTRL);
  localparam logic [WORD_W-1:0] SET_WORD  = WORD_W'(W_MASK_SET);
  localparam logic [WORD_W-1:0] CLR_WORD  = WORD_W'(W_MASK_CLR);

  logic                   run_d, run_q, run_en;
  logic [NUM_EVT:0]       mask_d, mask_q;
  logic                   mask_en;
  evt_sel_t [NUM_EVT-1:0] sel_q;
  logic                   wr_ctrl;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wdata;

  assign wr_ctrl = wr_en && (wr_word == CTRL_WORD);

  // Clear strobes act at the edge of the control write itself.
  assign evt_clr = wr_ctrl && wdata[CTRL_EVT_CLR];
  assign cyc_clr = wr_ctrl && wdata[CTRL_CYC_CLR];

  always_comb begin
    run_en = wr_ctrl;
    run_d  = wdata[CTRL_RUN];
  end

  always_comb begin
    mask_en = 1'b0;
    mask_d  = mask_q;
    if (wr_en && (wr_word == SET_WORD)) begin
      mask_en = 1'b1;
      mask_d  = mask_q | wdata[NUM_EVT:0];
    end else if (wr_en && (wr_word == CLR_WORD)) begin
      mask_en = 1'b1;
      mask_d  = mask_q & ~wdata[NUM_EVT:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sel
    localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(W_SEL_BASE + i);
    logic     sel_en;
    evt_sel_t sel_d;

    always_comb begin
      sel_en = wr_en && (wr_word == MY_WORD);
      sel_d  = wdata[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= '0;
      end else if (sel_en) begin
        sel_q[i] <= sel_d;
      end
    end
  end

  assign run  = run_q;
  assign mask = mask_q;
  assign sel  = sel_q;

endmodule

// File: rtl/perf_counter.sv
module perf_counter
  import perf_mon_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  step_t        step,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d, cnt_q;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (step != 2'd0);
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/perf_read_mux.sv
module perf_read_mux
  import perf_mon_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int WORD_W  = 6,
  parameter int CNT_W   = 32,
  parameter int WIDE_W  = 40
) (
  input  logic                                word_ok,
  input  logic [WORD_W-1:0]                   word,
  input  logic                                run,
  input  logic [NUM_EVT:0]                    mask,
  input  evt_sel_t [NUM_EVT-1:0]              sel,
  input  logic [CNT_W-1:0]                    cyc_cnt,
  input  logic [NUM_EVT-2:0][CNT_W-1:0]       narrow_cnt,
  input  logic [WIDE_W-1:0]                   wide_cnt,
  output logic [DATA_W-1:0]                   rdata
);

  localparam int HI_W = WIDE_W - CNT_W;
  localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(W_CTRL);
  localparam logic [WORD_W-1:0] SET_WORD  = WORD_W'(W_MASK_SET);
  localparam logic [WORD_W-1:0] CLR_WORD  = WORD_W'(W_MASK_CLR);
  localparam logic [WORD_W-1:0] CYC_WORD  = WORD_W'(W_CYCLES);
  localparam logic [WORD_W-1:0] LO_WORD   = WORD_W'(W_EVT_BASE + NUM_EVT - 1);
  localparam logic [WORD_W-1:0] HI_WORD   = WORD_W'(W_EVT_BASE + NUM_EVT);

  always_comb begin
    rdata = '0;
    if (word_ok) begin
      if (word == CTRL_WORD) rdata[CTRL_RUN] = run;
      if ((word == SET_WORD) || (word == CLR_WORD)) rdata[NUM_EVT:0] = mask;
      if (word == CYC_WORD) rdata[CNT_W-1:0] = cyc_cnt;
      for (int i = 0; i < NUM_EVT - 1; i++) begin
        if (word == WORD_W'(W_EVT_BASE + i)) rdata[CNT_W-1:0] = narrow_cnt[i];
      end
      if (word == LO_WORD) rdata[CNT_W-1:0] = wide_cnt[CNT_W-1:0];
      if (word == HI_WORD) rdata[HI_W-1:0]  = wide_cnt[WIDE_W-1:CNT_W];
      for (int i = 0; i < NUM_EVT; i++) begin
        if (word == WORD_W'(W_SEL_BASE + i)) rdata[1:0] = sel[i];
      end
    end
  end

endmodule

// File: rtl/bus_perf_counter.sv
module bus_perf_counter
  import perf_mon_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 32,
  parameter int WIDE_W  = 40,
  parameter int NUM_EVT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rd_beat,
  input  logic              wr_beat
);

  localparam int WORD_W = ADDR_W - 2;

  logic                            word_ok;
  logic [WORD_W-1:0]               word;
  logic                            run;
  logic                            evt_clr;
  logic                            cyc_clr;
  logic [NUM_EVT:0]                mask;
  evt_sel_t [NUM_EVT-1:0]          sel;
  step_t [NUM_EVT-1:0]             evt_step;
  step_t                           cyc_step;
  logic [CNT_W-1:0]                cyc_cnt;
  logic [NUM_EVT-2:0][CNT_W-1:0]   narrow_cnt;
  logic [WIDE_W-1:0]               wide_cnt;

  assign word_ok = (reg_addr[1:0] == 2'b00);
  assign word    = reg_addr[ADDR_W-1:2];

  perf_ctrl_regs #(
    .NUM_EVT (NUM_EVT),
    .WORD_W  (WORD_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en && word_ok),
    .wr_word (word),
    .wdata   (reg_wdata),
    .run     (run),
    .evt_clr (evt_clr),
    .cyc_clr (cyc_clr),
    .mask    (mask),
    .sel     (sel)
  );

  // Per-counter increment: 0, 1 or 2 beats in this cycle.
  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      if (run && mask[i]) begin
        evt_step[i] = {1'b0, sel[i][SEL_RD] & rd_beat} +
                      {1'b0, sel[i][SEL_WR] & wr_beat};
      end else begin
        evt_step[i] = 2'd0;
      end
    end
    cyc_step = {1'b0, run & mask[NUM_EVT]};
  end

  perf_counter #(.W(CNT_W)) cyc_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cyc_clr),
    .step  (cyc_step),
    .cnt   (cyc_cnt)
  );

  for (genvar i = 0; i < NUM_EVT - 1; i++) begin : g_narrow
    perf_counter #(.W(CNT_W)) evt_ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (evt_clr),
      .step  (evt_step[i]),
      .cnt   (narrow_cnt[i])
    );
  end

  perf_counter #(.W(WIDE_W)) wide_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (evt_clr),
    .step  (evt_step[NUM_EVT-1]),
    .cnt   (wide_cnt)
  );

  perf_read_mux #(
    .NUM_EVT (NUM_EVT),
    .WORD_W  (WORD_W),
    .CNT_W   (CNT_W),
    .WIDE_W  (WIDE_W)
  ) rmux_i (
    .word_ok    (word_ok),
    .word       (word),
    .run        (run),
    .mask       (mask),
    .sel        (sel),
    .cyc_cnt    (cyc_cnt),
    .narrow_cnt (narrow_cnt),
    .wide_cnt   (wide_cnt),
    .rdata      (reg_rdata)
  );

endmodule

// File: rtl/perf_mon_checker.sv
module perf_mon_checker #(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 32,
  parameter int WIDE_W  = 40,
  parameter int NUM_EVT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [31:0]       reg_wdata,
  input logic              run,
  input logic [NUM_EVT:0]  mask,
  input logic [CNT_W-1:0]  cyc_cnt,
  input logic [WIDE_W-1:0] wide_cnt
);

  logic wr_ctrl, wr_set, wr_clr;
  assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_W'(0));
  assign wr_set  = reg_wr_en && (reg_addr == ADDR_W'(4));
  assign wr_clr  = reg_wr_en && (reg_addr == ADDR_W'(8));

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> mask == ($past(mask) | $past(reg_wdata[NUM_EVT:0])));

  p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> mask == ($past(mask) & ~$past(reg_wdata[NUM_EVT:0])));

  p_run_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> run == $past(reg_wdata[0]));

  p_cyc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[2]) |=> cyc_cnt == '0);

  p_cyc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mask[NUM_EVT] && !(wr_ctrl && reg_wdata[2]))
      |=> cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1));

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_ctrl) |=> ($stable(cyc_cnt) && $stable(wide_cnt)));

  p_wide_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && reg_wdata[1])
      |=> WIDE_W'(wide_cnt - $past(wide_cnt)) <= WIDE_W'(2));

endmodule

bind bus_perf_counter perf_mon_checker #(
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W),
  .WIDE_W  (WIDE_W),
  .NUM_EVT (NUM_EVT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .run       (run),
  .mask      (mask),
  .cyc_cnt   (cyc_cnt),
  .wide_cnt  (wide_cnt)
);

// File: tb/bus_perf_counter_tb_top.sv
`timescale 1ns/1ps
module bus_perf_counter_tb_top;

  localparam int CW = 8;
  localparam int WW = 16;
  localparam longint unsigned CMASK = (64'd1 << CW) - 1;
  localparam longint unsigned WMASK = (64'd1 << WW) - 1;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rd_beat;
  logic        wr_beat;

  int n_checks = 0;
  int n_fail   = 0;

  bus_perf_counter #(
    .ADDR_W  (8),
    .CNT_W   (CW),
    .WIDE_W  (WW),
    .NUM_EVT (4)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rd_beat   (rd_beat),
    .wr_beat   (wr_beat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model
  longint unsigned m_cyc;
  longint unsigned m_evt [4];
  bit              m_run;
  bit [4:0]        m_mask;
  bit [1:0]        m_sel [4];

  initial begin
    m_cyc = 0; m_run = 0; m_mask = 0;
    for (int i = 0; i < 4; i++) begin m_evt[i] = 0; m_sel[i] = 0; end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      automatic bit      wv = reg_wr_en && (reg_addr[1:0] == 2'b00);
      automatic int      wd = int'(reg_addr[7:2]);
      automatic bit      ec = wv && wd == 0 && reg_wdata[1];
      automatic bit      cc = wv && wd == 0 && reg_wdata[2];
      for (int i = 0; i < 4; i++) begin
        if (ec) m_evt[i] = 0;
        else if (m_run && m_mask[i]) begin
          m_evt[i] = m_evt[i] + ((m_sel[i][0] && rd_beat) ? 1 : 0)
                              + ((m_sel[i][1] && wr_beat) ? 1 : 0);
          m_evt[i] = m_evt[i] & ((i == 3) ? WMASK : CMASK);
        end
      end
      if (cc) m_cyc = 0;
      else if (m_run && m_mask[4]) m_cyc = (m_cyc + 1) & CMASK;
      if (wv) begin
        if (wd == 0) m_run = reg_wdata[0];
        if (wd == 1) m_mask = m_mask | reg_wdata[4:0];
        if (wd == 2) m_mask = m_mask & ~reg_wdata[4:0];
        if (wd >= 12 && wd <= 15) m_sel[wd-12] = reg_wdata[1:0];
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int wd;
    if (a[1:0] != 2'b00) return 32'd0;
    wd = int'(a[7:2]);
    case (wd)
      0:       return {31'd0, m_run};
      1, 2:    return {27'd0, m_mask};
      3:       return 32'(m_cyc);
      4, 5, 6: return 32'(m_evt[wd-4]);
      7:       return 32'(m_evt[3] & CMASK);
      8:       return 32'(m_evt[3] >> CW);
      12, 13, 14, 15: return {30'd0, m_sel[wd-12]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    int wd;
    if (a[1:0] != 2'b00) return "R9";
    wd = int'(a[7:2]);
    if (wd == 0) return "R3";
    if (wd == 1 || wd == 2) return "R2";
    if (wd == 3) return "R4";
    if (wd >= 4 && wd <= 6) return "R6";
    if (wd == 7 || wd == 8) return "R7";
    if (wd >= 12 && wd <= 15) return "R6";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [31:0] got,
                     input logic [31:0] exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, got, exp);
    end
  endtask

  // One clock: drive at negedge, compare the addressed register at the next negedge.
  task automatic tick(input logic [7:0] a, input logic we, input logic [31:0] d,
                      input logic r, input logic w);
    reg_addr = a; reg_wr_en = we; reg_wdata = d; rd_beat = r; wr_beat = w;
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(a), reg_rdata, model_read(a), "per-cycle model compare");
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tick(a, 1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a);
    tick(a, 1'b0, 32'd0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] snap_cyc, snap_e0;
    rst_n = 1'b0; reg_addr = 0; reg_wr_en = 0; reg_wdata = 0; rd_beat = 0; wr_beat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, literal zero on every mapped register
    for (int a = 0; a <= 8'h3C; a += 4) begin
      rd(8'(a));
      chk("R1", reg_rdata, 32'd0, "reset value");
    end

    // R2: set/clear mask
    wr(8'h04, 32'h1F); chk("R2", reg_rdata, 32'h1F, "mask after set");
    wr(8'h08, 32'h05); chk("R2", reg_rdata, 32'h1A, "mask after clear");
    wr(8'h04, 32'h00); chk("R2", reg_rdata, 32'h1A, "zero set leaves mask");
    wr(8'h04, 32'hFFFF_FFE5); chk("R2", reg_rdata, 32'h1F, "mask re-set, high bits dropped");

    // R6: selects: c0 read, c1 write, c2 both, c3 both
    wr(8'h30, 32'h1); wr(8'h34, 32'h2); wr(8'h38, 32'h3); wr(8'h3C, 32'hFFFF_FFF3);
    chk("R6", reg_rdata, 32'h3, "select 3 readback");

    // R3: reset both and start in one write
    wr(8'h00, 32'h7); chk("R3", reg_rdata, 32'h1, "run reads 1, clear bits read 0");
    rd(8'h0C); chk("R3", reg_rdata, 32'h1, "cycle counter one step after clear+start");

    // Main traffic with varied beat patterns
    for (int i = 0; i < 60; i++) begin
      tick(8'(8'h0C + 4 * (i % 6)), 1'b0, 32'd0, (i % 3) != 0, (i % 5) < 2);
    end
    rd(8'h10); chk("R6", reg_rdata, model_read(8'h10), "counter0 read beats");
    rd(8'h18); chk("R6", reg_rdata, model_read(8'h18), "counter2 both beats");

    // R5: freeze
    wr(8'h00, 32'h0);
    rd(8'h0C); snap_cyc = reg_rdata;
    rd(8'h10); snap_e0 = reg_rdata;
    for (int i = 0; i < 10; i++) tick(8'h14, 1'b0, 32'd0, 1'b1, 1'b1);
    rd(8'h0C); chk("R5", reg_rdata, snap_cyc, "cycle count frozen");
    rd(8'h10); chk("R5", reg_rdata, snap_e0, "event count frozen");

    // R9: writes to read-only/unmapped/misaligned are ignored; reads there give 0
    wr(8'h0C, 32'hFFFF_FFFF); chk("R9", reg_rdata, snap_cyc, "write to cycle offset ignored");
    wr(8'h28, 32'hFFFF_FFFF); chk("R9", reg_rdata, 32'd0, "unmapped read 0");
    wr(8'h05, 32'h1F);        chk("R9", reg_rdata, 32'd0, "misaligned read 0");
    rd(8'h08);                chk("R9", reg_rdata, 32'h1F, "misaligned write left mask");

    // R6: per-counter gating via mask bit 1
    wr(8'h08, 32'h02);
    wr(8'h00, 32'h3);
    for (int i = 0; i < 20; i++) tick(8'h14, 1'b0, 32'd0, 1'b1, 1'b1);
    chk("R6", reg_rdata, 32'd0, "masked counter1 stays 0");
    rd(8'h18); chk("R6", reg_rdata, 32'd40, "counter2 adds 2 per cycle with both beats");

    // R8: cycle counter wraps after 2^CW clocks
    wr(8'h00, 32'h5);
    for (int i = 0; i < 255; i++) rd(8'h0C);
    chk("R8", reg_rdata, 32'd255, "cycle counter at max");
    rd(8'h0C); chk("R8", reg_rdata, 32'd0, "cycle counter wrapped");

    // R7: wide counter carry from low into high part
    wr(8'h3C, 32'h1);
    wr(8'h04, 32'h08);
    wr(8'h00, 32'h3);
    for (int i = 0; i < 300; i++) tick(8'h1C, 1'b0, 32'd0, 1'b1, 1'b0);
    wr(8'h00, 32'h0);
    rd(8'h1C); chk("R7", reg_rdata, 32'd44, "wide low part");
    rd(8'h20); chk("R7", reg_rdata, 32'd1, "wide high part");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule